// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of per-element byte addresses. A command carries an addressing mode, a scalar base address, a scalar stride and a requested element count. Three modes are supported. Unit stride walks consecutive elements. Constant stride steps by a signed scalar amount. Indexed mode adds one signed offset, taken from a separate index stream, to the base for each element, which serves both gather and scatter. Every offset is scaled by the element size in bytes.

Each address leaves the block together with its element number over a valid/ready handshake. When the last address is taken, a single-cycle completion pulse follows. The element count is clamped to the configured maximum. A zero count completes at once. Commands that arrive while an operation is running are dropped. Memory, data movement and register storage are handled elsewhere.

Top module: `vmag_top`

## Requirements
- R1: During and directly after reset, addr_valid_o, done_o and idx_ready_o are all low.
- R2: Mode code 0 (unit stride) produces the address base + i*ELEM_BYTES for element i. Mode code 3 behaves the same as code 0.
- R3: Mode code 1 (strided) produces the address base + i*stride*ELEM_BYTES. The stride is two's-complement signed, so negative and zero strides are legal.
- R4: Mode code 2 (indexed) produces the address base + idx*ELEM_BYTES, where idx is the signed value of the i-th accepted index element. Exactly one index is consumed per element, in order. idx_ready_o is never raised in the other modes.
- R5: An operation emits exactly as many addresses as its clamped length. Their element numbers run 0, 1, 2 and upward in handshake order.
- R6: A requested length above MAX_VL is treated as MAX_VL.
- R7: A command with length zero emits no address and raises done_o in the cycle after the start.
- R8: While addr_valid_o is high and addr_ready_i is low, addr_valid_o stays high and addr_o and elem_o do not change.
- R9: done_o is a one-cycle pulse in the cycle after the last address handshake. addr_valid_o is low while done_o is high.
- R10: start_i is ignored while an operation is in progress. The running address sequence and its length are unaffected.
- R11: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, taken only when idle |
| mode_i | input | 2 | Addressing mode: 0 unit, 1 strided, 2 indexed, 3 unit |
| base_i | input | ADDR_W | Scalar base byte address |
| stride_i | input | OFF_W | Signed stride in elements |
| vl_i | input | VL_W | Requested element count |
| idx_valid_i | input | 1 | Index element available |
| idx_data_i | input | OFF_W | Signed index element, in elements |
| idx_ready_o | output | 1 | Index element consumed this cycle when valid |
| addr_valid_o | output | 1 | Address output valid |
| addr_ready_i | input | 1 | Downstream takes the address |
| addr_o | output | ADDR_W | Element byte address |
| elem_o | output | EL_W | Element number of addr_o |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches several rules on every cycle. It checks that a stalled address and its element number stay frozen, that element numbers advance by one across back-to-back handshakes, and that the completion pulse lasts one cycle with no valid address beside it. It also checks that a zero-length command completes on the next cycle, that a start during an operation leaves the latched base and mode untouched, and that the index stream is requested only in indexed mode. Only the bench scenarios can show that the address values are arithmetically right in each mode. The same holds for negative strides and wrap-around, for clamping of oversize lengths, and for an operation emitting exactly its length under irregular ready and index-valid patterns.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

   typedef enum logic [1:0] {
      AM_UNIT   = 2'd0,
      AM_STRIDE = 2'd1,
      AM_INDEX  = 2'd2,
      AM_ALT    = 2'd3
   } amode_e;

endpackage

// File: rtl/vmag_scale.sv
// Sign-extends an element offset to address width and scales it by the
// element size; a shift is used when the size is a power of two.
module vmag_scale #(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 32,
   parameter int ELEM_BYTES = 8
) (
   input  logic signed [OFF_W-1:0]  off_i,
   output logic        [ADDR_W-1:0] scaled_o
);
   localparam bit IS_POW2 = (ELEM_BYTES & (ELEM_BYTES - 1)) == 0;
   localparam int SH      = $clog2(ELEM_BYTES);

   logic signed [ADDR_W-1:0] ext;
   assign ext = ADDR_W'(off_i);

   generate
      if (IS_POW2) begin : g_shift
         assign scaled_o = ext <<< SH;
      end else begin : g_mul
         assign scaled_o = ext * ADDR_W'(ELEM_BYTES);
      end
   endgenerate
endmodule

// File: rtl/vmag_ctrl.sv
// Operation sequencing: command acceptance, length clamp, issue count,
// completion pulse.
module vmag_ctrl #(
   parameter int MAX_VL = 64,
   parameter int VL_W   = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [VL_W-1:0] vl_i,
   input  logic            load_i,
   input  logic            last_fire_i,
   output logic            accept_o,
   output logic            busy_o,
   output logic            more_o,
   output logic [VL_W-1:0] issued_o,
   output logic            done_o
);
   localparam logic [VL_W-1:0] VL_MAX = VL_W'(MAX_VL);

   logic [VL_W-1:0] vl_c;
   logic [VL_W-1:0] vl_q;

   assign vl_c     = (vl_i > VL_MAX) ? VL_MAX : vl_i;
   assign accept_o = start_i && !busy_o;
   assign more_o   = issued_o < vl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o   <= 1'b0;
         vl_q     <= '0;
         issued_o <= '0;
         done_o   <= 1'b0;
      end else begin
         if (accept_o) begin
            busy_o   <= (vl_c != '0);
            vl_q     <= vl_c;
            issued_o <= '0;
            done_o   <= (vl_c == '0);
         end else begin
            done_o <= last_fire_i;
            if (last_fire_i) busy_o <= 1'b0;
            if (load_i) issued_o <= issued_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vmag_agen.sv
// Address accumulator plus the one-entry output register.
module vmag_agen #(
   parameter int ADDR_W = 32,
   parameter int VL_W   = 7,
   parameter int EL_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] base_q_i,
   input  logic [ADDR_W-1:0] step_i,
   input  logic              load_i,
   input  logic              use_idx_i,
   input  logic [ADDR_W-1:0] idx_off_i,
   input  logic              ready_i,
   input  logic [VL_W-1:0]   issued_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [EL_W-1:0]   elem_o
);
   logic [ADDR_W-1:0] acc;
   logic [ADDR_W-1:0] step_q;
   logic [ADDR_W-1:0] next_addr;

   assign next_addr = use_idx_i ? (base_q_i + idx_off_i) : acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         step_q  <= '0;
         valid_o <= 1'b0;
         addr_o  <= '0;
         elem_o  <= '0;
      end else begin
         if (accept_i) begin
            acc    <= base_i;
            step_q <= step_i;
         end else if (load_i && !use_idx_i) begin
            acc <= acc + step_q;
         end
         if (load_i) begin
            valid_o <= 1'b1;
            addr_o  <= next_addr;
            elem_o  <= EL_W'(issued_i);
         end else if (ready_i) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vmag_top.sv
module vmag_top
   import vmag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 32,
   parameter int MAX_VL     = 64,
   parameter int ELEM_BYTES = 8,
   localparam int VL_W      = $clog2(MAX_VL + 1),
   localparam int EL_W      = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  stride_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic              idx_valid_i,
   input  logic [OFF_W-1:0]  idx_data_i,
   output logic              idx_ready_o,
   output logic              addr_valid_o,
   input  logic              addr_ready_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [EL_W-1:0]   elem_o,
   output logic              done_o
);
   generate
      if (MAX_VL < 1) begin : g_bad_vl
         $error("MAX_VL must be at least 1");
      end
      if (ELEM_BYTES < 1) begin : g_bad_eb
         $error("ELEM_BYTES must be at least 1");
      end
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("OFF_W must not exceed ADDR_W");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(ELEM_BYTES);

   amode_e            mode_q;
   logic [ADDR_W-1:0] base_q;
   logic              accept, busy, more, load, fire, last_fire, slot_free, is_idx;
   logic [VL_W-1:0]   issued;
   logic [ADDR_W-1:0] stride_sc, idx_sc, step_sel;

   vmag_scale #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ELEM_BYTES(ELEM_BYTES)) u_sc_stride (
      .off_i    (stride_i),
      .scaled_o (stride_sc)
   );

   vmag_scale #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ELEM_BYTES(ELEM_BYTES)) u_sc_index (
      .off_i    (idx_data_i),
      .scaled_o (idx_sc)
   );

   assign step_sel  = (mode_i == AM_STRIDE) ? stride_sc : UNIT_STEP;
   assign is_idx    = (mode_q == AM_INDEX);
   assign slot_free = !addr_valid_o || addr_ready_i;
   assign load      = busy && more && slot_free && (!is_idx || idx_valid_i);
   assign fire      = addr_valid_o && addr_ready_i;
   assign last_fire = fire && !more;
   assign idx_ready_o = busy && is_idx && more && slot_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_UNIT;
         base_q <= '0;
      end else if (accept) begin
         mode_q <= amode_e'(mode_i);
         base_q <= base_i;
      end
   end

   vmag_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vl_i        (vl_i),
      .load_i      (load),
      .last_fire_i (last_fire),
      .accept_o    (accept),
      .busy_o      (busy),
      .more_o      (more),
      .issued_o    (issued),
      .done_o      (done_o)
   );

   vmag_agen #(.ADDR_W(ADDR_W), .VL_W(VL_W), .EL_W(EL_W)) u_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .base_i    (base_i),
      .base_q_i  (base_q),
      .step_i    (step_sel),
      .load_i    (load),
      .use_idx_i (is_idx),
      .idx_off_i (idx_sc),
      .ready_i   (addr_ready_i),
      .issued_i  (issued),
      .valid_o   (addr_valid_o),
      .addr_o    (addr_o),
      .elem_o    (elem_o)
   );
endmodule

// File: rtl/vmag_chk.sv
module vmag_chk #(
   parameter int ADDR_W = 32,
   parameter int VL_W   = 7,
   parameter int EL_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [VL_W-1:0]   vl_i,
   input logic              addr_valid_o,
   input logic              addr_ready_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [EL_W-1:0]   elem_o,
   input logic              done_o,
   input logic              idx_ready_o,
   input logic              busy,
   input logic [ADDR_W-1:0] base_q,
   input logic [1:0]        mode_q
);
   // R1
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!addr_valid_o && !done_o && !idx_ready_o));

   // R4
   a_r4_idx_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
      idx_ready_o |-> (mode_q == 2'd2));

   // R5
   a_r5_elem_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid_o && addr_ready_i) ##1 addr_valid_o |-> elem_o == EL_W'($past(elem_o) + 1'b1));

   // R7
   a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && vl_i == '0) |=> (done_o && !addr_valid_o));

   // R8
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o) && $stable(elem_o)));

   // R9
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !addr_valid_o);

   // R10
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> ($stable(base_q) && $stable(mode_q) && busy));
endmodule

bind vmag_top vmag_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W), .EL_W(EL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .vl_i         (vl_i),
   .addr_valid_o (addr_valid_o),
   .addr_ready_i (addr_ready_i),
   .addr_o       (addr_o),
   .elem_o       (elem_o),
   .done_o       (done_o),
   .idx_ready_o  (idx_ready_o),
   .busy         (busy),
   .base_q       (base_q),
   .mode_q       (mode_q)
);

// File: tb/sim_vmag_top.sv
`timescale 1ns/1ps
module sim_vmag_top;
   localparam int AW = 16;
   localparam int OW = 12;
   localparam int MV = 8;
   localparam int EB = 4;
   localparam int VW = 4;
   localparam int EW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [AW-1:0] base_i = '0;
   logic [OW-1:0] stride_i = '0;
   logic [VW-1:0] vl_i = '0;
   logic          idx_valid_i = 1'b0;
   logic [OW-1:0] idx_data_i = '0;
   logic          idx_ready_o;
   logic          addr_valid_o;
   logic          addr_ready_i = 1'b0;
   logic [AW-1:0] addr_o;
   logic [EW-1:0] elem_o;
   logic          done_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   vmag_top #(.ADDR_W(AW), .OFF_W(OW), .MAX_VL(MV), .ELEM_BYTES(EB)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .base_i(base_i), .stride_i(stride_i), .vl_i(vl_i),
      .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i), .idx_ready_o(idx_ready_o),
      .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
      .addr_o(addr_o), .elem_o(elem_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   function automatic int idx_val(input int i, input int seed);
      return ((i * 29 + seed * 13) % 97) - 48;
   endfunction

   function automatic logic [AW-1:0] exp_addr(input int mode, input int base, input int stride,
                                              input int i, input int seed);
      int off;
      if (mode == 1)      off = i * stride;
      else if (mode == 2) off = idx_val(i, seed);
      else                off = i;
      return AW'(base + off * EB);
   endfunction

   function automatic bit rdy(input int pat, input int cyc);
      if (pat == 0) return 1'b1;
      if (pat == 1) return (cyc % 3) != 1;
      return (cyc % 4) < 2;
   endfunction

   task automatic run_op(input int mode, input int base, input int stride, input int vl,
                         input int pat, input int seed, input bit poke);
      int  exp_n, got, k, cyc;
      bit  hold;
      logic [AW-1:0] h_addr;
      logic [EW-1:0] h_elem;
      string rq;
      exp_n = (vl > MV) ? MV : vl;   // R6 clamp
      rq = (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R2";
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'(mode); base_i = AW'(base);
      stride_i = OW'(stride); vl_i = VW'(vl);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (exp_n == 0) begin
         #1;
         chk(done_o == 1'b1, "R7 done after zero-length start", int'(done_o), 1);
         chk(addr_valid_o == 1'b0, "R7 no address", int'(addr_valid_o), 0);
         @(posedge clk); @(negedge clk); #1;
         chk(done_o == 1'b0, "R9 done single pulse", int'(done_o), 0);
         return;
      end
      got = 0; k = 0; cyc = 0; hold = 1'b0; h_addr = '0; h_elem = '0;
      while (got < exp_n && cyc < 300) begin
         addr_ready_i = rdy(pat, cyc);
         idx_valid_i  = (pat == 0) ? 1'b1 : ((cyc % 5) != 2);
         idx_data_i   = OW'(idx_val(k, seed));
         if (poke && cyc == 2) begin
            start_i = 1'b1; base_i = AW'(base ^ 16'h5A5A); vl_i = VW'(3); mode_i = 2'd1;
            stride_i = OW'(7);
         end
         #1;
         if (hold) begin
            chk(addr_valid_o && addr_o == h_addr && elem_o == h_elem, "R8 stall hold",
                int'(addr_o), int'(h_addr));
         end
         chk(done_o == 1'b0, "R9 no early done", int'(done_o), 0);
         if (mode != 2) chk(idx_ready_o == 1'b0, "R4 idx_ready only indexed", int'(idx_ready_o), 0);
         if (addr_valid_o && addr_ready_i) begin
            chk(int'(elem_o) == got, "R5 element number", int'(elem_o), got);
            chk(addr_o == exp_addr(mode, base, stride, got, seed),
                (poke ? "R10 sequence unaffected" : {rq, " R11 address"}),
                int'(addr_o), int'(exp_addr(mode, base, stride, got, seed)));
            got++;
         end
         hold = addr_valid_o && !addr_ready_i;
         h_addr = addr_o; h_elem = elem_o;
         if (idx_valid_i && idx_ready_o) k++;
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         cyc++;
      end
      addr_ready_i = 1'b1;
      #1;
      chk(got == exp_n, "R5 R6 address count", got, exp_n);
      chk(done_o == 1'b1, "R9 done after last handshake", int'(done_o), 1);
      chk(addr_valid_o == 1'b0, "R5 no extra address", int'(addr_valid_o), 0);
      if (mode == 2) chk(k == exp_n, "R4 one index per element", k, exp_n);
      @(posedge clk); @(negedge clk); #1;
      chk(done_o == 1'b0 && addr_valid_o == 1'b0, "R9 R10 idle after done",
          int'({done_o, addr_valid_o}), 0);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk); #1;
      chk(!addr_valid_o && !done_o && !idx_ready_o, "R1 reset outputs",
          int'({addr_valid_o, done_o, idx_ready_o}), 0);
      rst_n = 1'b1;
      for (int mode = 0; mode < 4; mode++) begin
         for (int vl = 0; vl < 12; vl++) begin
            for (int pat = 0; pat < 3; pat++) begin
               int ns;
               ns = (mode == 1) ? 5 : 1;
               for (int s = 0; s < ns; s++) begin
                  int stride, base;
                  case (s)
                     0: stride = 1;
                     1: stride = -3;
                     2: stride = 0;
                     3: stride = 100;
                     default: stride = -2048;
                  endcase
                  base = (vl % 3 == 0) ? 16'hFFF0 : (vl * 1234 + pat * 77) & 16'hFFFF;
                  run_op(mode, base, stride, vl, pat, vl + pat + s, 1'b0);
               end
            end
         end
      end
      run_op(0, 16'h0100, 1, 6, 1, 0, 1'b1);   // R10 start during operation
      run_op(2, 16'h8000, 1, 8, 2, 5, 1'b1);   // R10 in indexed mode
      run_op(1, 16'h0010, -1, 15, 0, 0, 1'b0); // R6 clamp with R11 wrap
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule